// File: doc/BRIEF.md
# E1 CRC-4 Sub-Multiframe Checker and Per-Second Error Counter

This block watches a received E1 stream that a multiframe aligner has already locked, and checks each half of the CRC-4 multiframe. Each half holds eight frames and is called a sub-multiframe (SMF). For every SMF the block computes a four-bit remainder. It compares that remainder with the four check bits that arrive in the next SMF, and counts one error for each mismatch.

A one-second tick from outside copies the running count into a 10-bit result and starts a new counting second. Two flags follow each result. One says that a new result is ready. The other says that a result was replaced before software read it. A software read strobe clears both flags. When a second holds more than 914 errors, the block raises an excessive-error flag. If the configuration allows it, the block also asks the basic-frame aligner to search for alignment again.

The upstream aligner gives a bit strobe and a start-of-frame strobe that marks the first bit of each frame. It also gives the index of the frame inside the current SMF (0 to 7) and a multiframe-lock level. A frame may have any number of bits, and the block needs no frame-length setting.

Top module: `e1_crc4_monitor`

## Requirements
- R1: The remainder is the CRC of the SMF with generator x^4 + x + 1, taken over every bit of the SMF in arrival order, most significant first. The first bit of each even-indexed frame (index 0, 2, 4 or 6) is a check-bit slot and counts as 0 in the calculation. A clean stream therefore produces no errors.
- R2: The check bits of an SMF are the bits in the slots of frames 0, 2, 4 and 6, in that order, and the first of them is the most significant. When they differ from the remainder of the SMF before them, one error is counted.
- R3: The running error count stops at 1023 and does not wrap.
- R4: On `sec_tick`, `err_count` takes the running count and the running count restarts from 0. Between ticks, `err_count` does not change.
- R5: `sec_tick` sets `new_data`. `stat_rd` clears both `new_data` and `overrun`, except in a cycle that also carries `sec_tick`.
- R6: A `sec_tick` that comes while `new_data` is still set, with no `stat_rd` in that cycle, sets `overrun`.
- R7: Each tick sets `excess_err` to 1 if the latched count is above 914, and to 0 otherwise.
- R8: `reframe_req` is high exactly while `excess_err` is 1, `crc_reframe_en` is 1 and `reframe_dis` is 0.
- R9: No error is counted while `mf_lock` is low. The first SMF that starts under lock only supplies a remainder, so its own check bits are never compared.
- R10: After reset, `err_count` is 0 and `new_data`, `overrun`, `excess_err` and `reframe_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received data bit |
| bit_vld | input | 1 | `rx_bit` carries a stream bit in this cycle |
| frame_start | input | 1 | This bit is the first bit of a frame |
| smf_frame_idx | input | 3 | Index of the current frame within its SMF |
| mf_lock | input | 1 | Multiframe alignment is held |
| sec_tick | input | 1 | One-cycle pulse each second |
| stat_rd | input | 1 | Software has read the result |
| crc_reframe_en | input | 1 | Allows a reframe request on excessive errors |
| reframe_dis | input | 1 | Blocks all reframe requests |
| err_count | output | 10 | Error count latched at the last tick |
| new_data | output | 1 | A result has been latched and not yet read |
| overrun | output | 1 | An unread result was replaced |
| excess_err | output | 1 | The last latched count was above 914 |
| reframe_req | output | 1 | Asks the aligner to search for basic-frame alignment again |

## Verification
The bench goes after four corner cases:

- **Threshold:** one second holds exactly 914 errors. A design with the threshold one too low would raise the excessive flag there.
- **Saturation:** one second holds 1030 errors. A counter that wraps would report 6 instead of 1023.
- **Lock loss:** the bench drops lock while sending corrupted check bits, then corrupts the first SMF after relock. A design that counts without lock, or that checks the seeding SMF, would report extra errors.
- **Read handshake:** two ticks arrive without a read. A bad handshake would leave `overrun` low or fail to clear it on read.

Every clean second must report zero errors. This catches a design that includes the check-bit slots in its remainder.

// File: rtl/e1crc_pkg.sv
package e1crc_pkg;
  localparam int unsigned CRC_W     = 4;
  localparam int unsigned SMF_IDX_W = 3;

  typedef logic [CRC_W-1:0] crc4_t;

  // One serial step of division by x^4 + x + 1 (message shifted by x^4).
  function automatic crc4_t crc4_step(input crc4_t cur, input logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction
endpackage

// File: rtl/e1crc_slot_decode.sv
module e1crc_slot_decode
  import e1crc_pkg::*;
(
  input  logic                 bit_vld,
  input  logic                 frame_start,
  input  logic [SMF_IDX_W-1:0] smf_frame_idx,
  output logic                 chk_slot,
  output logic                 smf_first,
  output logic [1:0]           chk_sel
);
  // The first bit of an even frame carries one check bit.
  always_comb begin
    chk_slot  = bit_vld && frame_start && !smf_frame_idx[0];
    smf_first = bit_vld && frame_start && (smf_frame_idx == '0);
    chk_sel   = smf_frame_idx[SMF_IDX_W-1:1];
  end
endmodule

// File: rtl/e1crc_calc.sv
module e1crc_calc
  import e1crc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       bit_vld,
  input  logic       chk_slot,
  input  logic       smf_first,
  input  logic [1:0] chk_sel,
  input  logic       mf_lock,
  output logic       err_hit
);
  crc4_t      crc_q, crc_n;
  crc4_t      ref_q, ref_n;
  crc4_t      rxc_q, rxc_n;
  logic [1:0] seed_q, seed_n;
  logic       err_q, err_n;
  logic       din;

  always_comb begin
    crc_n  = crc_q;
    ref_n  = ref_q;
    rxc_n  = rxc_q;
    seed_n = seed_q;
    err_n  = 1'b0;
    din    = chk_slot ? 1'b0 : rx_bit;
    if (bit_vld) begin
      crc_n = crc4_step(smf_first ? crc4_t'(0) : crc_q, din);
      if (chk_slot) rxc_n[2'd3 - chk_sel] = rx_bit;
      if (smf_first) begin
        ref_n = crc_q;
        if (mf_lock) begin
          if (seed_q == 2'd2) err_n = (rxc_q != ref_q);
          else                seed_n = seed_q + 2'd1;
        end
      end
    end
    if (!mf_lock) seed_n = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      ref_q  <= '0;
      rxc_q  <= '0;
      seed_q <= 2'd0;
      err_q  <= 1'b0;
    end else begin
      crc_q  <= crc_n;
      ref_q  <= ref_n;
      rxc_q  <= rxc_n;
      seed_q <= seed_n;
      err_q  <= err_n;
    end
  end

  assign err_hit = err_q;
endmodule

// File: rtl/e1crc_err_acc.sv
module e1crc_err_acc #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned EXC_LIMIT = 914
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_hit,
  input  logic             sec_tick,
  input  logic             stat_rd,
  input  logic             crc_reframe_en,
  input  logic             reframe_dis,
  output logic [CNT_W-1:0] err_count,
  output logic             new_data,
  output logic             overrun,
  output logic             excess_err,
  output logic             reframe_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(EXC_LIMIT);

  logic [CNT_W-1:0] run_q, run_n, run_inc, lat_q, lat_n;
  logic             nd_q, nd_n, ov_q, ov_n, ex_q, ex_n;

  always_comb begin
    run_inc = (err_hit && run_q != CNT_MAX) ? run_q + 1'b1 : run_q;
    run_n   = run_inc;
    lat_n   = lat_q;
    ex_n    = ex_q;
    nd_n    = stat_rd ? 1'b0 : nd_q;
    ov_n    = stat_rd ? 1'b0 : ov_q;
    if (sec_tick) begin
      lat_n = run_inc;
      run_n = '0;
      ex_n  = (run_inc > LIMIT);
      nd_n  = 1'b1;
      if (nd_q && !stat_rd) ov_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lat_q <= '0;
      nd_q  <= 1'b0;
      ov_q  <= 1'b0;
      ex_q  <= 1'b0;
    end else begin
      run_q <= run_n;
      lat_q <= lat_n;
      nd_q  <= nd_n;
      ov_q  <= ov_n;
      ex_q  <= ex_n;
    end
  end

  assign err_count   = lat_q;
  assign new_data    = nd_q;
  assign overrun     = ov_q;
  assign excess_err  = ex_q;
  assign reframe_req = ex_q && crc_reframe_en && !reframe_dis;
endmodule

// File: rtl/e1_crc4_monitor.sv
module e1_crc4_monitor
  import e1crc_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned EXC_LIMIT = 914
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_bit,
  input  logic                 bit_vld,
  input  logic                 frame_start,
  input  logic [SMF_IDX_W-1:0] smf_frame_idx,
  input  logic                 mf_lock,
  input  logic                 sec_tick,
  input  logic                 stat_rd,
  input  logic                 crc_reframe_en,
  input  logic                 reframe_dis,
  output logic [CNT_W-1:0]     err_count,
  output logic                 new_data,
  output logic                 overrun,
  output logic                 excess_err,
  output logic                 reframe_req
);
  logic       chk_slot, smf_first, err_hit;
  logic [1:0] chk_sel;

  e1crc_slot_decode u_dec (
    .bit_vld      (bit_vld),
    .frame_start  (frame_start),
    .smf_frame_idx(smf_frame_idx),
    .chk_slot     (chk_slot),
    .smf_first    (smf_first),
    .chk_sel      (chk_sel)
  );

  e1crc_calc u_calc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_bit   (rx_bit),
    .bit_vld  (bit_vld),
    .chk_slot (chk_slot),
    .smf_first(smf_first),
    .chk_sel  (chk_sel),
    .mf_lock  (mf_lock),
    .err_hit  (err_hit)
  );

  e1crc_err_acc #(.CNT_W(CNT_W), .EXC_LIMIT(EXC_LIMIT)) u_acc (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_hit       (err_hit),
    .sec_tick      (sec_tick),
    .stat_rd       (stat_rd),
    .crc_reframe_en(crc_reframe_en),
    .reframe_dis   (reframe_dis),
    .err_count     (err_count),
    .new_data      (new_data),
    .overrun       (overrun),
    .excess_err    (excess_err),
    .reframe_req   (reframe_req)
  );
endmodule

// File: rtl/e1crc_chk.sv
module e1crc_chk #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned EXC_LIMIT = 914
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             stat_rd,
  input logic             mf_lock,
  input logic             err_hit,
  input logic [CNT_W-1:0] err_count,
  input logic             new_data,
  input logic             overrun,
  input logic             excess_err,
  input logic             reframe_req
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EXC_LIMIT);

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(err_count)); // R4
  AST_NEWDATA_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> new_data); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !sec_tick |=> !new_data && !overrun); // R5
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && new_data && !stat_rd |=> overrun); // R6
  AST_EXCESS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> excess_err == (err_count > LIMIT)); // R7
  AST_REFRAME_NEEDS_EXCESS: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |-> (err_count > LIMIT)); // R8
  AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_lock |=> !err_hit); // R9
endmodule

bind e1_crc4_monitor e1crc_chk #(.CNT_W(CNT_W), .EXC_LIMIT(EXC_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .stat_rd    (stat_rd),
  .mf_lock    (mf_lock),
  .err_hit    (err_hit),
  .err_count  (err_count),
  .new_data   (new_data),
  .overrun    (overrun),
  .excess_err (excess_err),
  .reframe_req(reframe_req)
);

// File: tb/tb_e1_crc4_monitor.sv
module tb_e1_crc4_monitor;
  localparam int FB = 8;

  logic       clk = 1'b0;
  logic       rst_n, rx_bit, bit_vld, frame_start, mf_lock;
  logic [2:0] smf_frame_idx;
  logic       sec_tick, stat_rd, crc_reframe_en, reframe_dis;
  logic [9:0] err_count;
  logic       new_data, overrun, excess_err, reframe_req;

  always #5 clk = ~clk;

  e1_crc4_monitor dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_vld(bit_vld),
    .frame_start(frame_start), .smf_frame_idx(smf_frame_idx), .mf_lock(mf_lock),
    .sec_tick(sec_tick), .stat_rd(stat_rd), .crc_reframe_en(crc_reframe_en),
    .reframe_dis(reframe_dis), .err_count(err_count), .new_data(new_data),
    .overrun(overrun), .excess_err(excess_err), .reframe_req(reframe_req)
  );

  typedef struct packed { logic [9:0] cnt; logic exc; } exp_t;
  exp_t exp_q[$];

  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  logic [3:0] prev_rem = 4'h0;
  bit   prev_bad = 0;
  int   seed = 0;
  int   exp_run = 0;
  logic tick_seen;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one sub-multiframe of 8 frames, the model updated at its first bit.
  task automatic send_smf(input bit bad, input bit tick_here, input bit rd_here);
    logic [3:0] cb, r;
    if (mf_lock) begin
      if (seed == 2 && prev_bad) exp_run = (exp_run < 1023) ? exp_run + 1 : 1023;
      if (seed < 2) seed++;
    end else seed = 0;
    cb = prev_rem ^ (bad ? 4'b0101 : 4'b0000);
    r  = 4'h0;
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < FB; p++) begin
        logic b, fb;
        bit   is_c;
        is_c = (p == 0) && (f % 2 == 0);
        b    = is_c ? cb[3 - f/2] : 1'($urandom);
        @(negedge clk);
        rx_bit = b; bit_vld = 1'b1; frame_start = (p == 0);
        smf_frame_idx = 3'(f); sec_tick = 1'b0; stat_rd = 1'b0;
        if (tick_here && (f*FB + p) == 10) begin
          sec_tick = 1'b1;
          exp_q.push_back('{cnt: 10'(exp_run), exc: (exp_run > 914)});
          exp_run = 0;
        end
        if (rd_here && (f*FB + p) == 30) stat_rd = 1'b1;
        fb = r[3] ^ (is_c ? 1'b0 : b);
        r  = {r[2:0], 1'b0} ^ {2'b00, fb, fb};
      end
    end
    @(negedge clk);
    bit_vld = 1'b0; frame_start = 1'b0; sec_tick = 1'b0; stat_rd = 1'b0;
    prev_rem = r; prev_bad = bad;
  endtask

  // Monitor: compares each latched result against the scoreboard queue.
  always @(posedge clk) tick_seen <= sec_tick;
  always @(negedge clk) begin
    if (tick_seen === 1'b1 && rst_n === 1'b1) begin
      exp_t e;
      if (exp_q.size() == 0) chk("R4 unexpected latch", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R4 latched count", int'(err_count), int'(e.cnt));
        chk("R7 excess flag", int'(excess_err), int'(e.exc));
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_bit = 1'b0; bit_vld = 1'b0; frame_start = 1'b0;
    smf_frame_idx = 3'd0; mf_lock = 1'b0; sec_tick = 1'b0; stat_rd = 1'b0;
    crc_reframe_en = 1'b1; reframe_dis = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 reset count", int'(err_count), 0);
    chk("R10 reset new_data", int'(new_data), 0);
    chk("R10 reset overrun", int'(overrun), 0);
    chk("R10 reset excess/reframe", int'(excess_err | reframe_req), 0);
    rst_n = 1'b1;
    mf_lock = 1'b1;

    // R2: two counted mismatches; the first SMF only seeds (R9)
    for (int k = 0; k < 8; k++) send_smf(k == 0 || k == 3 || k == 5, 0, 0);
    send_smf(0, 1, 0);
    chk("R2 mismatches counted", int'(err_count), 2);
    chk("R5 new_data set", int'(new_data), 1);
    send_smf(0, 0, 1);
    chk("R5 read clears new_data", int'(new_data), 0);

    // R6: two ticks without a read
    send_smf(1, 0, 0);
    send_smf(0, 1, 0);
    chk("R6 no overrun after read", int'(overrun), 0);
    send_smf(0, 1, 0);
    chk("R6 overrun set", int'(overrun), 1);
    chk("R5 new_data still set", int'(new_data), 1);
    send_smf(0, 0, 1);
    chk("R5 read clears both", int'(new_data | overrun), 0);

    // R9: corruption while unlocked and in the seeding SMF is ignored
    mf_lock = 1'b0;
    send_smf(1, 0, 0);
    send_smf(1, 0, 0);
    mf_lock = 1'b1;
    send_smf(1, 0, 0);
    send_smf(1, 0, 0);
    send_smf(0, 1, 0);
    chk("R9 lock gating", int'(err_count), 1);
    send_smf(0, 0, 1);

    // R7: exactly 914 errors is not excessive
    for (int k = 0; k < 914; k++) send_smf(1, 0, 0);
    send_smf(0, 1, 0);
    chk("R7 count at threshold", int'(err_count), 914);
    chk("R8 no request at threshold", int'(reframe_req), 0);
    send_smf(0, 0, 1);

    // R3: 1030 errors saturate, R7 excessive
    for (int k = 0; k < 1030; k++) send_smf(1, 0, 0);
    send_smf(0, 1, 0);
    chk("R3 saturation", int'(err_count), 1023);
    chk("R8 request enabled", int'(reframe_req), 1);
    reframe_dis = 1'b1;
    @(negedge clk);
    chk("R8 request disabled", int'(reframe_req), 0);
    reframe_dis = 1'b0; crc_reframe_en = 1'b0;
    @(negedge clk);
    chk("R8 request not enabled", int'(reframe_req), 0);
    crc_reframe_en = 1'b1;
    send_smf(0, 0, 1);

    // R1: clean stream counts nothing
    for (int k = 0; k < 3; k++) send_smf(0, 0, 0);
    send_smf(0, 1, 0);
    chk("R1 clean stream", int'(err_count), 0);
    chk("R8 request dropped", int'(reframe_req), 0);
    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule